// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block watches 128 interrupt request lines and turns the most urgent one into a handler address. Each source has its own enable bit and a 2-bit urgency level. The block selects the winning source among those that are both requesting and enabled. It then produces `BASE + STRIDE * n`, where `n` is the winner's source number and both terms are registers that software programs. When nothing qualifies, the output is the all-ones value.

Software reads the vector through a small word-addressed register port. The same port holds the base, the stride, the enable words and the level words. A service routine can read the vector, handle that source, and read it again. Each read then yields the next lower-ranked pending source, until the all-ones value shows that nothing is left. The vector is held in a register, so every result is one clock behind its inputs.

Top module: `irq_vector_gen`

## Requirements
- R1: While `rst` is high, `vec_o` becomes 0x00000000 at each rising edge. Base, stride, every enable word and every level word also reset to zero, so a read of any of them returns zero.
- R2: The base register (address 0x00) and the stride register (address 0x01) are 32-bit read/write registers. A write is taken at the rising edge where `reg_we` is high, and `reg_rdata` returns the value written.
- R3: For winning source `n`, the vector equals `base + stride * n`, truncated to 32 bits (it wraps modulo 2^32).
- R4: When no source is both requesting and enabled, the vector is 0xFFFFFFFF. Servicing sources one at a time produces each lower-ranked vector in turn and then 0xFFFFFFFF.
- R5: A qualifying source with a numerically larger level wins over every qualifying source with a smaller level, whatever its source number.
- R6: Among qualifying sources that share the highest level, the one with the lowest source number wins.
- R7: A source whose enable bit is 0 never wins, whatever its request or level.
- R8: `vec_o` changes exactly one clock edge after a change on `irq_i` or on any register. Between edges it holds its value.
- R9: Address 0x02 reads the current vector. Writes to address 0x02 are ignored and change no register and not the vector.
- R10: Source `n` is `irq_i[n]`. Its enable bit is bit `n%32` of the enable word at address `0x04 + n/32`. Its level is bits `2*(n%16)+1 : 2*(n%16)` of the level word at address `0x08 + n/16`.
- R11: The enable words and level words are read/write. A read returns the last value written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 128 | Request lines; bit n is source n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| vec_o | output | 32 | Registered handler vector, all ones when idle |

## Verification
A fault in the selection tree shows up at the ports as a wrong source number. The vector is then off by a whole multiple of the stride, or it shows the all-ones value while a source is pending. Either appears one edge after the request pattern that exposes it. A fault in the register decode shows up as a read-back mismatch on the very next read. It can also show as a vector computed from a base, stride, enable or level that software never wrote. The stimulus places competing sources across word boundaries, at both ends of the index range and at equal and unequal levels, so that a mis-ordered comparison cannot hide.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int SRC_COUNT = 128;
    localparam int REG_W     = 32;
    localparam int LVL_W     = 2;
    localparam int IDX_W     = $clog2(SRC_COUNT);
    localparam int RADDR_W   = 5;

    // word addresses of the register port
    localparam int ADR_BASE   = 0;
    localparam int ADR_STRIDE = 1;
    localparam int ADR_VEC    = 2;
    localparam int ADR_EN0    = 4;
    localparam int ADR_LVL0   = 8;

    localparam logic [REG_W-1:0] IDLE_VEC = '1;

    // one contender in the selection tree
    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } cand_t;

    // lo always carries the lower source numbers, so ties favour it
    function automatic cand_t cand_pick(input cand_t lo, input cand_t hi);
        if (lo.hit && (!hi.hit || lo.lvl >= hi.lvl))
            return lo;
        return hi;
    endfunction

    function automatic logic [REG_W-1:0] vec_addr(input logic [REG_W-1:0] base,
                                                  input logic [REG_W-1:0] stride,
                                                  input logic [IDX_W-1:0] idx);
        return base + stride * REG_W'(idx);
    endfunction

endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int DATA_W  = REG_W,
    parameter int PRIO_W  = LVL_W,
    parameter int ADDR_W  = RADDR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic [DATA_W-1:0]         vec_i,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [DATA_W-1:0]         base_o,
    output logic [DATA_W-1:0]         stride_o,
    output logic [NUM_SRC-1:0]        en_o,
    output logic [NUM_SRC*PRIO_W-1:0] lvl_o
);

    localparam int EN_WORDS  = NUM_SRC / DATA_W;
    localparam int LVL_WORDS = (NUM_SRC * PRIO_W) / DATA_W;
    localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(ADR_BASE);
    localparam logic [ADDR_W-1:0] A_STRIDE = ADDR_W'(ADR_STRIDE);
    localparam logic [ADDR_W-1:0] A_VEC    = ADDR_W'(ADR_VEC);

    logic [DATA_W-1:0] base_q, stride_q;
    logic [DATA_W-1:0] en_rd  [EN_WORDS];
    logic [DATA_W-1:0] lvl_rd [LVL_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            stride_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_BASE)   base_q   <= reg_wdata;
            if (reg_addr == A_STRIDE) stride_q <= reg_wdata;
        end
    end

    for (genvar w = 0; w < EN_WORDS; w++) begin : g_en
        localparam logic [ADDR_W-1:0] A_W = ADDR_W'(ADR_EN0 + w);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                            q <= '0;
            else if (reg_we && reg_addr == A_W) q <= reg_wdata;
        end
        assign en_o[w*DATA_W +: DATA_W] = q;
        assign en_rd[w] = (reg_addr == A_W) ? q : '0;
    end

    for (genvar w = 0; w < LVL_WORDS; w++) begin : g_lvl
        localparam logic [ADDR_W-1:0] A_W = ADDR_W'(ADR_LVL0 + w);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                            q <= '0;
            else if (reg_we && reg_addr == A_W) q <= reg_wdata;
        end
        assign lvl_o[w*DATA_W +: DATA_W] = q;
        assign lvl_rd[w] = (reg_addr == A_W) ? q : '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_BASE)   reg_rdata = base_q;
        if (reg_addr == A_STRIDE) reg_rdata = stride_q;
        if (reg_addr == A_VEC)    reg_rdata = vec_i;
        for (int w = 0; w < EN_WORDS; w++)  reg_rdata = reg_rdata | en_rd[w];
        for (int w = 0; w < LVL_WORDS; w++) reg_rdata = reg_rdata | lvl_rd[w];
    end

    assign base_o   = base_q;
    assign stride_o = stride_q;

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int PRIO_W  = LVL_W
) (
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] lvl_i,
    output cand_t                     win_o
);

    localparam int NODES = 2 * NUM_SRC - 1;
    localparam int LEAF0 = NUM_SRC - 1;

    // heap layout: node k has children 2k+1 and 2k+2, leaves in source order
    cand_t node [NODES];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
        assign node[LEAF0 + i] = '{hit: req_i[i] & en_i[i],
                                   lvl: lvl_i[i*PRIO_W +: PRIO_W],
                                   idx: IDX_W'(i)};
    end

    for (genvar k = 0; k < LEAF0; k++) begin : g_node
        assign node[k] = cand_pick(node[2*k+1], node[2*k+2]);
    end

    assign win_o = node[0];

endmodule

// File: rtl/irqv_vec_reg.sv
module irqv_vec_reg
    import irqv_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cand_t             win_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] stride_i,
    output logic [DATA_W-1:0] vec_o
);

    logic [DATA_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst)            vec_q <= '0;
        else if (win_i.hit) vec_q <= vec_addr(base_i, stride_i, win_i.idx);
        else                vec_q <= IDLE_VEC;
    end

    assign vec_o = vec_q;

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irqv_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int DATA_W  = REG_W,
    parameter int PRIO_W  = LVL_W,
    parameter int ADDR_W  = RADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [DATA_W-1:0]  vec_o
);

    logic [DATA_W-1:0]         base_w, stride_w;
    logic [NUM_SRC-1:0]        en_w;
    logic [NUM_SRC*PRIO_W-1:0] lvl_w;
    cand_t                     win_w;

    irqv_regs #(
        .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .vec_i(vec_o), .reg_rdata(reg_rdata),
        .base_o(base_w), .stride_o(stride_w), .en_o(en_w), .lvl_o(lvl_w)
    );

    irqv_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) arb_i (
        .req_i(irq_i), .en_i(en_w), .lvl_i(lvl_w), .win_o(win_w)
    );

    irqv_vec_reg #(
        .DATA_W(DATA_W)
    ) vreg_i (
        .clk(clk), .rst(rst), .win_i(win_w),
        .base_i(base_w), .stride_i(stride_w), .vec_o(vec_o)
    );

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
    import irqv_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int DATA_W  = REG_W,
    parameter int PRIO_W  = LVL_W,
    parameter int ADDR_W  = RADDR_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC-1:0]        irq_i,
    input logic [NUM_SRC-1:0]        en,
    input logic [NUM_SRC*PRIO_W-1:0] lvl,
    input logic [DATA_W-1:0]         base,
    input logic [DATA_W-1:0]         stride,
    input logic                      reg_we,
    input logic [ADDR_W-1:0]         reg_addr,
    input cand_t                     win,
    input logic [DATA_W-1:0]         vec_o
);

    logic outranked, tie_lost;
    always_comb begin
        outranked = 1'b0;
        tie_lost  = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (irq_i[i] && en[i] && lvl[i*PRIO_W +: PRIO_W] > win.lvl)
                outranked = 1'b1;
            if (irq_i[i] && en[i] && lvl[i*PRIO_W +: PRIO_W] == win.lvl && IDX_W'(i) < win.idx)
                tie_lost = 1'b1;
        end
    end

    // R1
    vec_reset_zero_chk: assert property (@(posedge clk) rst |=> vec_o == '0);

    // R4
    idle_sentinel_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_i & en) == '0) |=> vec_o == IDLE_VEC);

    // R5
    no_higher_level_chk: assert property (@(posedge clk) disable iff (rst)
        win.hit |-> !outranked);

    // R6
    lowest_on_tie_chk: assert property (@(posedge clk) disable iff (rst)
        win.hit |-> !tie_lost);

    // R7
    winner_qualifies_chk: assert property (@(posedge clk) disable iff (rst)
        win.hit |-> (irq_i[win.idx] && en[win.idx]));

    // R8
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(irq_i) && $stable(en) && $stable(lvl)
         && $stable(base) && $stable(stride)) |=> $stable(vec_o));

    // R9
    vec_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(ADR_VEC)) |=> ($stable(base) && $stable(stride)));

endmodule

bind irq_vector_gen irqv_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .en(en_w), .lvl(lvl_w),
    .base(base_w), .stride(stride_w), .reg_we(reg_we), .reg_addr(reg_addr),
    .win(win_w), .vec_o(vec_o)
);

// File: tb/irq_vector_gen_tb_top.sv
module irq_vector_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [6:0]  sa;
        logic [1:0]  pa;
        logic [6:0]  sb;
        logic [1:0]  pb;
        logic [31:0] base;
        logic [31:0] stride;
        logic [6:0]  win;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{7'd5,   2'd1, 7'd9,   2'd1, 32'h0000_1000, 32'h0000_0010, 7'd5},
        '{7'd5,   2'd1, 7'd9,   2'd3, 32'h0000_1000, 32'h0000_0010, 7'd9},
        '{7'd127, 2'd2, 7'd0,   2'd0, 32'h0000_2000, 32'h0000_0004, 7'd127},
        '{7'd0,   2'd3, 7'd127, 2'd3, 32'h0000_2000, 32'h0000_0004, 7'd0},
        '{7'd64,  2'd0, 7'd63,  2'd0, 32'h0000_0000, 32'h0000_0008, 7'd63},
        '{7'd31,  2'd2, 7'd32,  2'd2, 32'h4000_0000, 32'h0000_0100, 7'd31},
        '{7'd1,   2'd1, 7'd1,   2'd1, 32'hFFFF_FFF0, 32'h0000_0020, 7'd1},
        '{7'd100, 2'd2, 7'd3,   2'd1, 32'h8000_0000, 32'h0100_0000, 7'd100},
        '{7'd127, 2'd3, 7'd126, 2'd3, 32'hFFFF_0000, 32'h1000_0000, 7'd126}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] irq = '0;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [31:0]  vec;

    int n_chk = 0;
    int n_err = 0;
    logic [1:0] lvl_m [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_gen dut_i (
        .clk(clk), .rst(rst), .irq_i(irq), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_o(vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic set_lvl(input int n, input logic [1:0] p);
        logic [31:0] wd;
        int grp;
        lvl_m[n] = p;
        grp = n / 16;
        for (int j = 0; j < 16; j++) wd[2*j +: 2] = lvl_m[grp*16 + j];
        wr(5'(8 + grp), wd);
    endtask

    task automatic clear_lvls();
        for (int i = 0; i < 128; i++) lvl_m[i] = 2'd0;
        for (int w = 0; w < 8; w++) wr(5'(8 + w), 32'h0);
    endtask

    function automatic logic [31:0] vexp(input logic [31:0] b, input logic [31:0] s, input int n);
        return b + s * 32'(n);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        for (int i = 0; i < 128; i++) lvl_m[i] = 2'd0;

        // R1: reset state
        irq = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 vec in reset", vec, 32'h0);
        rd(5'd0, d);  check("R1 base reset", d, 32'h0);
        rd(5'd1, d);  check("R1 stride reset", d, 32'h0);
        rd(5'd5, d);  check("R1 enable word reset", d, 32'h0);
        rd(5'd12, d); check("R1 level word reset", d, 32'h0);

        // R7: all requests high but nothing enabled
        rst = 1'b0;
        settle();
        check("R7 all disabled gives idle", vec, 32'hFFFF_FFFF);

        // R2: base and stride read/write
        wr(5'd0, 32'h1234_5678);
        wr(5'd1, 32'h0000_0040);
        rd(5'd0, d); check("R2 base readback", d, 32'h1234_5678);
        rd(5'd1, d); check("R2 stride readback", d, 32'h0000_0040);

        // R11 / R10: enable and level words, field positions
        for (int w = 0; w < 4; w++) wr(5'(4 + w), 32'hFFFF_FFFF);
        rd(5'd6, d); check("R11 enable word readback", d, 32'hFFFF_FFFF);
        set_lvl(37, 2'd2);
        rd(5'd10, d); check("R10 level field of source 37", d, 32'h0000_0800);

        // R3 R5 R6 R10: table of competing source pairs
        for (int k = 0; k < NVEC; k++) begin
            irq = '0;
            clear_lvls();
            wr(5'd0, TBL[k].base);
            wr(5'd1, TBL[k].stride);
            set_lvl(int'(TBL[k].sa), TBL[k].pa);
            set_lvl(int'(TBL[k].sb), TBL[k].pb);
            irq[TBL[k].sa] = 1'b1;
            irq[TBL[k].sb] = 1'b1;
            settle();
            check($sformatf("R3/R5/R6/R10 table entry %0d", k), vec,
                  vexp(TBL[k].base, TBL[k].stride, int'(TBL[k].win)));
        end

        // R7: disabled high-level source loses to enabled low-level one
        irq = '0;
        clear_lvls();
        wr(5'd0, 32'h0000_1000);
        wr(5'd1, 32'h0000_0010);
        set_lvl(10, 2'd3);
        set_lvl(20, 2'd1);
        irq[10] = 1'b1; irq[20] = 1'b1;
        wr(5'd4, 32'hFFFF_FBFF);
        settle();
        check("R7 disabled source skipped", vec, vexp(32'h1000, 32'h10, 20));

        // R8: one-clock latency
        irq = '0; irq[50] = 1'b1;
        #1;
        check("R8 vec holds before edge", vec, vexp(32'h1000, 32'h10, 20));
        settle();
        check("R8 vec updated after one edge", vec, vexp(32'h1000, 32'h10, 50));

        // R9: writes to the vector address are ignored
        wr(5'd2, 32'hDEAD_BEEF);
        settle();
        check("R9 vec unchanged by write", vec, vexp(32'h1000, 32'h10, 50));
        rd(5'd0, d); check("R9 base unchanged", d, 32'h0000_1000);
        rd(5'd1, d); check("R9 stride unchanged", d, 32'h0000_0010);

        // R4: service loop read through the register port
        wr(5'd4, 32'hFFFF_FFFF);
        clear_lvls();
        set_lvl(3, 2'd1);
        set_lvl(70, 2'd2);
        irq = '0; irq[3] = 1'b1; irq[70] = 1'b1; irq[90] = 1'b1;
        settle();
        rd(5'd2, d); check("R4 service step 1", d, vexp(32'h1000, 32'h10, 70));
        irq[70] = 1'b0; settle();
        rd(5'd2, d); check("R4 service step 2", d, vexp(32'h1000, 32'h10, 3));
        irq[3] = 1'b0; settle();
        rd(5'd2, d); check("R4 service step 3", d, vexp(32'h1000, 32'h10, 90));
        irq[90] = 1'b0; settle();
        rd(5'd2, d); check("R4 service done", d, 32'hFFFF_FFFF);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule